// File: doc/BRIEF.md
# V.110 Frame Receiver

This block takes the serial bit stream of one B channel and recovers 80-bit V.110 frames from it. After reset, and after every frame close, it hunts for frame alignment. A frame starts with an all-zero alignment octet, and the receiver locks when it sees a run of eight zero bits followed by a one bit. That one bit is the leading bit of the first data octet. Once locked, it assembles the nine data octets of the frame least-significant bit first. Each octet passes through a three-entry FIFO to a byte-wide valid/ready output. The alignment octet is never delivered.

Each frame close produces a one-cycle `frame_done` pulse. The pulse carries the number of octets stored, a synchronization-error flag and an overrun flag. A frame closes in one of three ways: normally after the ninth data octet, early on FIFO overrun, or on an enter-hunt command. A receive-frame interrupt pulse comes with the close when `irq_en` is high. After any close the receiver returns to hunting on its own.

Top module: `v110_frame_rx`

## Requirements
- R1: While hunting, the receiver locks only on eight consecutive zero bits followed by a one bit, counting accepted bits only. That one bit becomes bit 0 of the first data octet. A run of seven zeros followed by a one does not lock.
- R2: Data octets are assembled with the first received bit in bit 0 and bit 7 last. Nine octets are delivered per frame on `out_data` and the alignment octet is never delivered. A delivered octet stays on `out_data` with `out_valid` high until it is taken with `out_ready` high.
- R3: After the ninth data octet, `frame_done` pulses for one cycle, in the cycle after the clock edge that took the last bit. It reports `done_count`=9, `done_se`=0 and `done_ov`=0 for a clean frame, and the receiver then hunts again.
- R4: If bit 0 of any data octet is 0, that octet is still delivered and reception runs to the end of the frame. The close then reports `done_se`=1.
- R5: The FIFO holds three octets. If an octet completes while the FIFO is full and nothing is taken in that cycle, the new octet replaces the most recently stored one. The older octets keep their order.
- R6: An overrun closes the frame at once. The close reports `done_ov`=1, `done_se`=0 (overrun wins) and `done_count` equal to the octets received including the one that overran. The rest of the frame is ignored until a new alignment.
- R7: If an octet completes while the FIFO is full and an octet is taken in that same cycle, this is not an overrun and the frame goes on.
- R8: A pulse on `hunt_cmd` while a frame is in progress closes it. The close reports `done_ov`=0, the octets stored so far and any synchronization error seen. The bit presented in that cycle is dropped. A pulse while already hunting produces no `frame_done`.
- R9: `rxf_irq` pulses together with `frame_done` when `irq_en` is high at the close. It stays low when `irq_en` is low.
- R10: During and right after reset, `out_valid`, `frame_done` and `rxf_irq` are low.
- R11: Cycles with `bit_valid` low advance neither alignment nor octet assembly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | A channel bit is present this cycle |
| bit_in | input | 1 | Channel bit |
| hunt_cmd | input | 1 | Abandon the frame and restart the alignment search |
| irq_en | input | 1 | Mask for the receive-frame interrupt |
| out_ready | input | 1 | Consumer takes the octet on `out_data` |
| out_valid | output | 1 | An octet is waiting |
| out_data | output | 8 | Oldest stored octet |
| frame_done | output | 1 | One-cycle frame close pulse |
| done_count | output | 4 | Octets stored in the closed frame |
| done_se | output | 1 | Synchronization error in the closed frame |
| done_ov | output | 1 | Overrun closed the frame |
| rxf_irq | output | 1 | Receive-frame interrupt pulse |

## Verification
The completion of an octet can land in the same cycle as the consumer draining the full FIFO. The bench provokes this by holding `out_ready` low until three octets are stored, then raising it together with the last bit of the fourth octet. The run passes only if no overrun close appears, all nine octets arrive in order and the frame closes normally. The contrasting case lets the last octet both overrun and carry a bad alignment bit. There the single close must show the overrun flag alone, and the overwritten octet must be missing from the stream.

// File: rtl/v110_rx_pkg.sv
package v110_rx_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic [3:0] count;
        logic       se;
        logic       ov;
    } frame_stat_t;

endpackage

// File: rtl/v110_align_hunt.sv
module v110_align_hunt #(
    parameter int ZERO_RUN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic clear,
    output logic found
);

    typedef struct packed {
        logic [ZERO_RUN-1:0] hist;
    } hunt_st_t;

    hunt_st_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.hist = '1;
        end else if (bit_valid) begin
            d.hist = {q.hist[ZERO_RUN-2:0], bit_in};
        end
    end

    assign found = bit_valid && bit_in && !clear && (q.hist == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hist <= '1;
        end else begin
            q <= d;
        end
    end

    // R1
    hunt_needs_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> bit_in);

endmodule

// File: rtl/v110_octet_fifo.sv
module v110_octet_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             not_empty,
    output logic             full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wr;
        logic [AW-1:0]               rd;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic     take;
    logic     clobber;
    logic [AW-1:0] last_wr;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + AW'(1));
    endfunction

    always_comb begin
        d       = q;
        take    = pop && (q.cnt != '0);
        clobber = push && (q.cnt == CW'(DEPTH)) && !take;
        last_wr = (q.wr == '0) ? AW'(DEPTH - 1) : AW'(q.wr - AW'(1));
        if (clobber) begin
            d.mem[last_wr] = din;
        end else if (push) begin
            d.mem[q.wr] = din;
            d.wr        = step(q.wr);
        end
        if (take) begin
            d.rd = step(q.rd);
        end
        case ({push && !clobber, take})
            2'b10:   d.cnt = CW'(q.cnt + CW'(1));
            2'b01:   d.cnt = CW'(q.cnt - CW'(1));
            default: d.cnt = q.cnt;
        endcase
    end

    assign dout      = q.mem[q.rd];
    assign not_empty = (q.cnt != '0);
    assign full      = (q.cnt == CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R5
    clobber_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);

    // R2
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty && !pop) |=> (not_empty && $stable(dout)));

endmodule

// File: rtl/v110_frame_rx.sv
module v110_frame_rx #(
    parameter int FRAME_OCTETS = 10,
    parameter int FIFO_DEPTH   = 3,
    parameter int ZERO_RUN     = 8,
    parameter int CW           = $clog2(FRAME_OCTETS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_valid,
    input  logic          bit_in,
    input  logic          hunt_cmd,
    input  logic          irq_en,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          frame_done,
    output logic [CW-1:0] done_count,
    output logic          done_se,
    output logic          done_ov,
    output logic          rxf_irq
);
    import v110_rx_pkg::*;

    localparam int DATA_OCTETS = FRAME_OCTETS - 1;

    typedef struct packed {
        rx_state_e     state;
        logic [2:0]    bitcnt;
        logic [CW-1:0] octcnt;
        logic [7:0]    shreg;
        logic          se_acc;
        logic          done;
        logic [CW-1:0] cnt_out;
        logic          se_out;
        logic          ov_out;
        logic          irq;
    } rx_st_t;

    rx_st_t q, d;

    logic       found;
    logic       clear_hist;
    logic       push;
    logic       fifo_full;
    logic       pop_now;
    logic [7:0] octet_w;
    logic       se_now;
    logic [CW-1:0] oct_next;

    assign pop_now = out_valid && out_ready;

    v110_align_hunt #(.ZERO_RUN(ZERO_RUN)) u_hunt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .clear     (clear_hist),
        .found     (found)
    );

    v110_octet_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .din       (octet_w),
        .pop       (out_ready),
        .dout      (out_data),
        .not_empty (out_valid),
        .full      (fifo_full)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.irq      = 1'b0;
        clear_hist = 1'b0;
        push       = 1'b0;
        octet_w    = {bit_in, q.shreg[7:1]};
        se_now     = q.se_acc | ~octet_w[0];
        oct_next   = CW'(q.octcnt + CW'(1));

        if (hunt_cmd) begin
            clear_hist = 1'b1;
            d.state    = ST_HUNT;
            if (q.state == ST_RECV) begin
                d.done    = 1'b1;
                d.irq     = irq_en;
                d.cnt_out = q.octcnt;
                d.se_out  = q.se_acc;
                d.ov_out  = 1'b0;
            end
        end else begin
            case (q.state)
                ST_HUNT: begin
                    if (found) begin
                        d.state  = ST_RECV;
                        d.bitcnt = 3'd1;
                        d.shreg  = 8'h80;
                        d.octcnt = '0;
                        d.se_acc = 1'b0;
                    end
                end
                default: begin
                    if (bit_valid) begin
                        d.shreg  = octet_w;
                        d.bitcnt = 3'(q.bitcnt + 3'd1);
                        if (q.bitcnt == 3'd7) begin
                            push     = 1'b1;
                            d.octcnt = oct_next;
                            d.se_acc = se_now;
                            if (fifo_full && !pop_now) begin
                                d.state    = ST_HUNT;
                                clear_hist = 1'b1;
                                d.done     = 1'b1;
                                d.irq      = irq_en;
                                d.cnt_out  = oct_next;
                                d.se_out   = 1'b0;
                                d.ov_out   = 1'b1;
                            end else if (oct_next == CW'(DATA_OCTETS)) begin
                                d.state    = ST_HUNT;
                                clear_hist = 1'b1;
                                d.done     = 1'b1;
                                d.irq      = irq_en;
                                d.cnt_out  = oct_next;
                                d.se_out   = se_now;
                                d.ov_out   = 1'b0;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign frame_done = q.done;
    assign done_count = q.cnt_out;
    assign done_se    = q.se_out;
    assign done_ov    = q.ov_out;
    assign rxf_irq    = q.irq;

    // R1
    lock_on_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HUNT && found && !hunt_cmd) |=> (q.state == ST_RECV));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (done_count <= CW'(DATA_OCTETS)));

    // R6
    ov_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && done_ov) |-> !done_se);

    // R8
    hunt_cmd_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt_cmd && q.state == ST_RECV) |=> (frame_done && !done_ov && q.state == ST_HUNT));

    // R9
    irq_with_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_irq |-> frame_done);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !hunt_cmd) |=> ($stable(q.bitcnt) && $stable(q.octcnt)));

endmodule

// File: tb/v110_frame_rx_test.sv
module v110_frame_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       hunt_cmd = 1'b0;
    logic       irq_en = 1'b1;
    logic       out_ready = 1'b1;
    logic       out_valid;
    logic [7:0] out_data;
    logic       frame_done;
    logic [3:0] done_count;
    logic       done_se;
    logic       done_ov;
    logic       rxf_irq;

    int total = 0;
    int bad = 0;
    int n_done = 0;
    int n_irq = 0;
    logic [3:0] last_cnt;
    logic last_se, last_ov, last_irq;
    logic [7:0] got_q[$];

    always #2 clk = ~clk;

    v110_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .hunt_cmd(hunt_cmd), .irq_en(irq_en), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .frame_done(frame_done),
        .done_count(done_count), .done_se(done_se), .done_ov(done_ov),
        .rxf_irq(rxf_irq)
    );

    // stimulus table: nine data octets (octet 0 in the low byte), expected SE, gapped bits
    localparam logic [71:0] TAB_DATA [4] = '{
        {8'hFF, 8'hF1, 8'hE3, 8'hC5, 8'hA7, 8'h99, 8'h3B, 8'h5D, 8'h7F},
        {8'h11, 8'h23, 8'h40, 8'h57, 8'h69, 8'h7B, 8'h8D, 8'h9F, 8'hB1},
        {8'h01, 8'h03, 8'h05, 8'h07, 8'h09, 8'h0B, 8'h0D, 8'h0F, 8'h11},
        {8'h02, 8'h55, 8'hAB, 8'hCD, 8'hEF, 8'h13, 8'h35, 8'h57, 8'h79}
    };
    localparam logic TAB_SE  [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic TAB_GAP [4] = '{1'b0, 1'b0, 1'b1, 1'b0};

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) got_q.push_back(out_data);
            if (frame_done) begin
                n_done++;
                last_cnt = done_count;
                last_se  = done_se;
                last_ov  = done_ov;
                last_irq = rxf_irq;
            end
            if (rxf_irq) n_irq++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(posedge clk); #1;
        bit_valid = 1'b1;
        bit_in    = b;
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        bit_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_octet(input logic [7:0] b, input logic gap,
                              input int rdy_at, input logic rdy_val);
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            bit_valid = 1'b1;
            bit_in    = b[k];
            if (k == rdy_at) out_ready = rdy_val;
            if (gap) begin
                @(posedge clk); #1;
                bit_valid = 1'b0;
            end
        end
    endtask

    task automatic send_frame(input logic [71:0] data, input logic gap);
        for (int k = 0; k < 8; k++) send_bit(1'b0);
        for (int o = 0; o < 9; o++) send_octet(data[o*8 +: 8], gap, -1, 1'b0);
    endtask

    task automatic pulse_hunt();
        @(posedge clk); #1;
        bit_valid = 1'b0;
        hunt_cmd  = 1'b1;
        @(posedge clk); #1;
        hunt_cmd  = 1'b0;
    endtask

    task automatic check_bytes(input string req, input logic [7:0] exp[$]);
        check({req, " octet total"}, got_q.size(), exp.size());
        for (int k = 0; k < exp.size() && k < got_q.size(); k++)
            check({req, " octet value"}, int'(got_q[k]), int'(exp[k]));
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        logic [7:0] exp_q[$];

        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 out_valid in reset", int'(out_valid), 0);
        check("R10 frame_done in reset", int'(frame_done), 0);
        check("R10 rxf_irq in reset", int'(rxf_irq), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 out_valid after reset", int'(out_valid), 0);

        // table walk: R1 false start, R2/R3/R4/R9/R11
        for (int i = 0; i < 4; i++) begin
            got_q.delete();
            exp_q.delete();
            base   = n_done;
            irq_en = (i != 2);
            for (int k = 0; k < 7; k++) send_bit(1'b0);
            send_bit(1'b1);
            for (int k = 0; k < 8; k++) send_bit(1'b1);
            send_frame(TAB_DATA[i], TAB_GAP[i]);
            idle(4);
            check("R1 R3 one close per frame", n_done - base, 1);
            check("R3 count", int'(last_cnt), 9);
            check("R4 se flag", int'(last_se), int'(TAB_SE[i]));
            check("R3 ov clear", int'(last_ov), 0);
            check("R9 irq follows mask", int'(last_irq), int'(i != 2));
            for (int o = 0; o < 9; o++) exp_q.push_back(TAB_DATA[i][o*8 +: 8]);
            check_bytes("R2 R11 table", exp_q);
        end
        irq_en = 1'b1;

        // R5 R6 overrun in mid frame: octet 3 replaces octet 2
        got_q.delete();
        base = n_done;
        out_ready = 1'b0;
        send_frame(TAB_DATA[0], 1'b0);
        idle(3);
        check("R6 single close", n_done - base, 1);
        check("R6 count", int'(last_cnt), 4);
        check("R6 ov", int'(last_ov), 1);
        check("R6 se", int'(last_se), 0);
        check("R9 irq on overrun", int'(last_irq), 1);
        out_ready = 1'b1;
        idle(6);
        exp_q = '{8'h7F, 8'h5D, 8'h99};
        check_bytes("R5 overwrite newest", exp_q);
        check("R6 rest ignored", n_done - base, 1);

        // R6 overrun and bad alignment bit on the last octet together
        got_q.delete();
        base = n_done;
        for (int k = 0; k < 8; k++) send_bit(1'b0);
        for (int o = 0; o < 9; o++)
            send_octet(TAB_DATA[3][o*8 +: 8], 1'b0, (o == 5) ? 3 : -1, 1'b0);
        idle(3);
        check("R6 close", n_done - base, 1);
        check("R6 count last", int'(last_cnt), 9);
        check("R6 ov priority", int'(last_ov), 1);
        check("R6 se hidden", int'(last_se), 0);
        out_ready = 1'b1;
        idle(6);
        exp_q = '{8'h79, 8'h57, 8'h35, 8'h13, 8'hEF, 8'hCD, 8'hAB, 8'h02};
        check_bytes("R6 drain", exp_q);

        // R7 push and pop in the same cycle with a full FIFO
        got_q.delete();
        base = n_done;
        out_ready = 1'b0;
        for (int k = 0; k < 8; k++) send_bit(1'b0);
        for (int o = 0; o < 9; o++)
            send_octet(TAB_DATA[0][o*8 +: 8], 1'b0, (o == 3) ? 7 : -1, 1'b1);
        idle(6);
        check("R7 close", n_done - base, 1);
        check("R7 no overrun", int'(last_ov), 0);
        check("R7 count", int'(last_cnt), 9);
        exp_q.delete();
        for (int o = 0; o < 9; o++) exp_q.push_back(TAB_DATA[0][o*8 +: 8]);
        check_bytes("R7 all octets", exp_q);

        // R8 enter-hunt command in frame, then while hunting
        got_q.delete();
        base = n_done;
        for (int k = 0; k < 8; k++) send_bit(1'b0);
        for (int o = 0; o < 4; o++) send_octet(TAB_DATA[1][o*8 +: 8], 1'b0, -1, 1'b0);
        pulse_hunt();
        idle(2);
        check("R8 close", n_done - base, 1);
        check("R8 count", int'(last_cnt), 4);
        check("R8 ov", int'(last_ov), 0);
        check("R8 se", int'(last_se), 0);
        for (int o = 4; o < 9; o++) send_octet(TAB_DATA[1][o*8 +: 8], 1'b0, -1, 1'b0);
        idle(2);
        pulse_hunt();
        idle(3);
        check("R8 no close while hunting", n_done - base, 1);
        exp_q = '{8'hB1, 8'h9F, 8'h8D, 8'h7B};
        check_bytes("R8 stored octets", exp_q);
        got_q.delete();
        send_frame(TAB_DATA[0], 1'b0);
        idle(4);
        check("R8 relock", n_done - base, 2);
        check("R8 relock count", int'(last_cnt), 9);
        check("R9 irq total", n_irq, n_done - 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule